// File: doc/BRIEF.md
# DMA Channel Enable Control Register

This block holds the enable state for a group of DMA channels in one 16-bit control word. Software changes the word by writing a mask together with a mode bit: the mode bit decides whether the ones in the mask turn the matching stored bits on or off. Bits whose mask position is zero keep their value. As a result, one channel can be switched without a read-modify-write sequence.

The stored word has nine per-channel bits, a master enable and a priority flag. Each channel's effective enable output is its stored bit ANDed with the master enable. The priority flag is driven straight to an output, where bus arbitration logic uses it to keep the processor off the bus while blitter DMA is running.

A read of the register returns the stored bits. The two status lines from the blitter (busy and zero) are placed in the upper bits of the read word. They are live values and are never stored. The remaining upper bit positions read as zero.

Top module: `dmactl_top`

## Requirements
- R1: On a clock edge with `wr_en` high and `wr_data[15]` = 1, every stored bit in positions 10..0 whose `wr_data` bit is 1 becomes 1.
- R2: On a clock edge with `wr_en` high and `wr_data[15]` = 0, every stored bit in positions 10..0 whose `wr_data` bit is 1 becomes 0.
- R3: On a write, stored bits whose `wr_data` bit is 0 keep their value.
- R4: A write is visible on `rd_data`, `chan_en` and `blt_prio` right after the clock edge that samples it, and not before that edge.
- R5: `rd_data[14]` shows `blt_busy` and `rd_data[13]` shows `blt_zero` combinationally, in the same cycle, whether or not a write happens.
- R6: `rd_data[15]`, `rd_data[12]` and `rd_data[11]` always read 0. Writing 1s to positions 15..11 changes no stored bit.
- R7: Stored bit 9 is the master enable. `chan_en[i]` equals stored bit i AND stored bit 9, for i = 0..8. The channel order is: 8 bit-plane, 7 copper, 6 blitter, 5 sprite, 4 disk, 3..0 audio 3..0.
- R8: `blt_prio` equals stored bit 10 and does not depend on the master enable.
- R9: While `rst_n` is low, all stored bits are 0, so `chan_en` = 0, `blt_prio` = 0 and `rd_data[10:0]` = 0.
- R10: While `wr_en` is low, no stored bit changes, whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 16 | Mode bit 15 plus bit mask 10..0 |
| blt_busy | input | 1 | Blitter busy status |
| blt_zero | input | 1 | Blitter zero-result status |
| rd_data | output | 16 | Read word: stored bits plus live status |
| chan_en | output | 9 | Effective per-channel DMA enables |
| blt_prio | output | 1 | Blitter bus priority flag |

## Verification
A write takes effect one cycle later. It is sampled on a rising edge, and `rd_data`, `chan_en` and `blt_prio` take the new value right after that same edge. The bench therefore drives on the falling edge and samples shortly after the next rising edge. For R4 it also samples just before that rising edge to confirm the old value is still present. The status bits have no register in their path, so the bench changes `blt_busy` or `blt_zero` and checks `rd_data` within the same cycle, with no clock edge in between.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
    localparam int DW       = 16;
    localparam int MODE_BIT = 15;
    localparam int BUSY_BIT = 14;
    localparam int ZERO_BIT = 13;
endpackage

// File: rtl/dmactl_store.sv
module dmactl_store
    import dmactl_pkg::*;
#(
    parameter int NCHAN = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DW-1:0]        wr_data,
    output logic [NCHAN+1:0]     bits_q
);
    localparam int STW = NCHAN + 2;

    typedef struct packed {
        logic             prio;
        logic             master;
        logic [NCHAN-1:0] chan;
    } ctl_t;

    ctl_t             st_d, st_q;
    logic [STW-1:0]   mask;

    // only positions that hold state take part in the mask
    assign mask = wr_data[STW-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_data[MODE_BIT]) st_d = ctl_t'(st_q | mask);
            else                   st_d = ctl_t'(st_q & ~mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_q = st_q;

    // R1: a set-mode write leaves every masked bit at 1
    a_r1_set_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MODE_BIT]) |=> ((bits_q & $past(mask)) == $past(mask)));

    // R2: a clear-mode write leaves every masked bit at 0
    a_r2_clear_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[MODE_BIT]) |=> ((bits_q & $past(mask)) == '0));

    // R3: bits outside the mask keep their value
    a_r3_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((bits_q ^ $past(bits_q)) & ~$past(mask)) == '0));

    // R10: no change without a write strobe
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bits_q));
endmodule

// File: rtl/dmactl_gate.sv
module dmactl_gate #(
    parameter int NCHAN = 9
) (
    input  logic [NCHAN+1:0] bits,
    output logic [NCHAN-1:0] chan_en,
    output logic             prio
);
    localparam int MASTER = NCHAN;
    localparam int PRIO   = NCHAN + 1;

    for (genvar i = 0; i < NCHAN; i++) begin : g_chan
        assign chan_en[i] = bits[i] & bits[MASTER];
    end

    assign prio = bits[PRIO];
endmodule

// File: rtl/dmactl_rdmux.sv
module dmactl_rdmux
    import dmactl_pkg::*;
#(
    parameter int NCHAN = 9
) (
    input  logic [NCHAN+1:0] bits,
    input  logic             busy,
    input  logic             zero,
    output logic [DW-1:0]    rd
);
    localparam int STW = NCHAN + 2;

    always_comb begin
        rd            = '0;
        rd[STW-1:0]   = bits;
        rd[BUSY_BIT]  = busy;
        rd[ZERO_BIT]  = zero;
    end
endmodule

// File: rtl/dmactl_top.sv
module dmactl_top
    import dmactl_pkg::*;
#(
    parameter int NCHAN = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    input  logic             blt_busy,
    input  logic             blt_zero,
    output logic [15:0]      rd_data,
    output logic [NCHAN-1:0] chan_en,
    output logic             blt_prio
);
    localparam int STW    = NCHAN + 2;
    localparam int MASTER = NCHAN;
    localparam int PRIO   = NCHAN + 1;

    logic [STW-1:0] bits_q;

    dmactl_store #(.NCHAN(NCHAN)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .bits_q  (bits_q)
    );

    dmactl_gate #(.NCHAN(NCHAN)) u_gate (
        .bits    (bits_q),
        .chan_en (chan_en),
        .prio    (blt_prio)
    );

    dmactl_rdmux #(.NCHAN(NCHAN)) u_rdmux (
        .bits (bits_q),
        .busy (blt_busy),
        .zero (blt_zero),
        .rd   (rd_data)
    );

    // R7: master off as read back forces every channel output off
    a_r7_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[MASTER] |-> (chan_en == '0));

    // R8: priority output tracks the read-back priority bit
    a_r8_prio_out: assert property (@(posedge clk) disable iff (!rst_n)
        blt_prio == rd_data[PRIO]);

    // R5: status inputs appear live in the read word
    a_r5_status_live: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[BUSY_BIT] == blt_busy) && (rd_data[ZERO_BIT] == blt_zero));

    // R6: unused positions never read as 1
    a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15] == 1'b0) && (rd_data[12:STW] == '0));
endmodule

// File: tb/tb_dmactl_top.sv
`timescale 1ns/1ps
module tb_dmactl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        blt_busy = 1'b0;
    logic        blt_zero = 1'b0;
    logic [15:0] rd_data;
    logic [8:0]  chan_en;
    logic        blt_prio;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    dmactl_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .blt_busy(blt_busy), .blt_zero(blt_zero),
        .rd_data(rd_data), .chan_en(chan_en), .blt_prio(blt_prio)
    );

    // {wr_data, busy, zero, exp rd_data, exp chan_en, exp prio}
    localparam int NV = 11;
    localparam logic [43:0] VEC [0:NV-1] = '{
        {16'h83FF, 1'b0, 1'b0, 16'h03FF, 9'h1FF, 1'b0},  // R1 set all channels + master
        {16'h0200, 1'b0, 1'b0, 16'h01FF, 9'h000, 1'b0},  // R7 master off
        {16'h8200, 1'b0, 1'b0, 16'h03FF, 9'h1FF, 1'b0},  // R7 master on
        {16'h0005, 1'b0, 1'b0, 16'h03FA, 9'h1FA, 1'b0},  // R2 R3 clear bits 0 and 2
        {16'h8400, 1'b0, 1'b0, 16'h07FA, 9'h1FA, 1'b1},  // R8 set priority
        {16'hF800, 1'b1, 1'b1, 16'h67FA, 9'h1FA, 1'b1},  // R6 R5 set on upper bits only
        {16'h7800, 1'b0, 1'b1, 16'h27FA, 9'h1FA, 1'b1},  // R6 clear on upper bits only
        {16'h0000, 1'b1, 1'b0, 16'h47FA, 9'h1FA, 1'b1},  // R3 empty mask
        {16'h0200, 1'b0, 1'b0, 16'h05FA, 9'h000, 1'b1},  // R8 prio without master
        {16'h81FF, 1'b0, 1'b0, 16'h05FF, 9'h000, 1'b1},  // R7 channels on, master off
        {16'h07FF, 1'b0, 1'b0, 16'h0000, 9'h000, 1'b0}   // R2 clear everything
    };

    task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cycle(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        #2;
        wr_en   = 1'b0;
    endtask

    initial begin : watchdog
        #100000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk16("R9 rd_data in reset", rd_data, 16'h0000);
        chk16("R9 chan_en in reset", {7'b0, chan_en}, 16'h0000);
        chk16("R9 blt_prio in reset", {15'b0, blt_prio}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            blt_busy = VEC[i][27];
            blt_zero = VEC[i][26];
            write_cycle(VEC[i][43:28]);
            chk16($sformatf("R1/R2 vec%0d rd_data", i), rd_data, VEC[i][25:10]);
            chk16($sformatf("R7 vec%0d chan_en", i), {7'b0, chan_en}, {7'b0, VEC[i][9:1]});
            chk16($sformatf("R8 vec%0d blt_prio", i), {15'b0, blt_prio}, {15'b0, VEC[i][0]});
        end

        // R5 status is live within the cycle
        @(negedge clk);
        blt_busy = 1'b1; blt_zero = 1'b0;
        #1;
        chk16("R5 busy live", rd_data, 16'h4000);
        blt_busy = 1'b0; blt_zero = 1'b1;
        #1;
        chk16("R5 zero live", rd_data, 16'h2000);
        blt_zero = 1'b0;

        // R4 write not visible before the edge, visible after it
        @(negedge clk);
        wr_en = 1'b1; wr_data = 16'h8211;
        #2;
        chk16("R4 before edge", rd_data, 16'h0000);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        chk16("R4 after edge", rd_data, 16'h0211);
        chk16("R4 chan_en after edge", {7'b0, chan_en}, 16'h0011);

        // R10 data without strobe has no effect
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h87FF;
        repeat (2) @(posedge clk);
        #1;
        chk16("R10 idle rd_data", rd_data, 16'h0211);
        chk16("R10 idle chan_en", {7'b0, chan_en}, 16'h0011);
        wr_data = 16'h0000;

        // R9 reset mid-operation clears state
        write_cycle(16'h87FF);
        chk16("R1 full set", rd_data, 16'h07FF);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk16("R9 async reset rd_data", rd_data, 16'h0000);
        chk16("R9 async reset chan_en", {7'b0, chan_en}, 16'h0000);
        chk16("R9 async reset blt_prio", {15'b0, blt_prio}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule